// File: doc/BRIEF.md
# DDR3 Device-Side Command Decoder

This block sits on the memory side of a DDR3 command bus. On every rising clock edge where clock enable is high, it samples the active-low select and strobe pins, the bank-address bits and the address bus. It turns each sample into one command event: activate, read, write, precharge, mode-register load, refresh or no-operation. The event is reported on a registered output, one cycle after the sampling edge.

Alongside decoding, the block keeps the open or idle state and the open row of every bank. It also holds four mode registers. From these it checks each command against the current bank state, and it resolves the burst length of each read and write from the burst-mode field. When on-the-fly chopping is selected, the burst length comes from an address bit instead.

A model or monitor of a DDR3 device uses this block as its command front end. The outputs carry the target bank, the row or column, the auto-precharge and all-bank flags, the effective burst length, and a single-cycle protocol-error pulse for illegal sequences.

Top module: `ddr3_cmd_frontend`

## Requirements
- R1: Pins are sampled at the rising edge, and the event appears on the outputs after that same edge. With {cs_n,ras_n,cas_n,we_n} the codes are: 0000 mode load, 0001 refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read. `cmd_kind` encodes 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 mode load, 6 refresh. `cmd_bank` carries `ba` for any non-zero kind. `cmd_valid` and `proto_err` are never high together.
- R2: A sample with cs_n high produces no event (kind 0, valid and error low), and it leaves bank and mode state unchanged.
- R3: A sample with cke low produces no event and leaves all bank and mode state unchanged.
- R4: Activate to an idle bank sets its bit in `bank_open`, stores the row, and reports `cmd_row` equal to the address.
- R5: Activate to an open bank raises `proto_err` for one cycle with `cmd_valid` low, and bank state is unchanged.
- R6: Read or write to an open bank reports `cmd_col` = addr[9:0], `cmd_row` = the row stored at activation and `cmd_autopre` = addr[10]. When addr[10] is high, the bank is idle after that edge.
- R7: Read or write to an idle bank raises `proto_err` with `cmd_valid` low, and bank state is unchanged.
- R8: Precharge with addr[10] low closes only bank `ba`. With addr[10] high it closes every bank and sets `cmd_allbank`. Precharge is always valid.
- R9: Mode load writes the whole address into mode register ba[1:0], which is exposed as `mode_regs[15*i +: 15]`. ba[2] does not affect the choice.
- R10: `cmd_burst8` on a valid read or write is set by mode register 0 bits [1:0]. 00 gives 1 (burst of 8). 10 gives 0 (chop of 4). 01 gives addr[12]. 11 gives 1.
- R11: Refresh is valid only when all banks are idle. Otherwise it raises `proto_err` and changes nothing.
- R12: After reset all banks are idle, all mode registers are zero and every event output is zero.
- R13: Code 0110 and code 0111 produce no event and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends decoding |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address |
| addr | input | 15 | Row, column, flag or op-code bits |
| cmd_valid | output | 1 | Accepted command reported this cycle |
| cmd_kind | output | 3 | Event code (see R1) |
| cmd_bank | output | 3 | Target bank |
| cmd_row | output | 15 | Row opened, or row being accessed |
| cmd_col | output | 10 | Column of a read or write |
| cmd_autopre | output | 1 | Auto-precharge requested |
| cmd_burst8 | output | 1 | 1 = burst of 8, 0 = chop of 4 |
| cmd_allbank | output | 1 | Precharge applied to all banks |
| proto_err | output | 1 | Illegal command for the bank state |
| bank_open | output | 8 | Open flag per bank |
| mode_regs | output | 60 | Four 15-bit mode registers, register 0 lowest |

## Verification
The bench builds the block with its defaults: eight banks, a 15-bit address, 10-bit columns and four mode registers. This configuration is small enough to sweep every bank against every burst-mode setting, both values of the chop bit and both read and write. Every bank is driven into both its open and idle states, so each legal and illegal pairing of command and bank state is reached. A reference model in the bench tracks bank, row and mode state, and it predicts every output field after each command. This includes the suspended, deselected and unused-code samples.

// File: rtl/ddr3_cmd_pkg.sv
package ddr3_cmd_pkg;
    typedef enum logic [2:0] {
        EV_NOP = 3'd0,
        EV_ACT = 3'd1,
        EV_RD  = 3'd2,
        EV_WR  = 3'd3,
        EV_PRE = 3'd4,
        EV_MRS = 3'd5,
        EV_REF = 3'd6
    } ev_e;
endpackage

// File: rtl/ddr3_cmd_classify.sv
module ddr3_cmd_classify
    import ddr3_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output ev_e  kind
);
    always_comb begin
        unique case ({cs_n, ras_n, cas_n, we_n})
            4'b0000: kind = EV_MRS;
            4'b0001: kind = EV_REF;
            4'b0010: kind = EV_PRE;
            4'b0011: kind = EV_ACT;
            4'b0100: kind = EV_WR;
            4'b0101: kind = EV_RD;
            default: kind = EV_NOP;
        endcase
    end
endmodule

// File: rtl/ddr3_burst_resolve.sv
module ddr3_burst_resolve (
    input  logic [1:0] bl_mode,
    input  logic       chop_pin,
    output logic       burst8
);
    always_comb begin
        unique case (bl_mode)
            2'b01:   burst8 = chop_pin;
            2'b10:   burst8 = 1'b0;
            default: burst8 = 1'b1;
        endcase
    end
endmodule

// File: rtl/ddr3_mode_regs.sv
module ddr3_mode_regs #(
    parameter  int NUM_MR  = 4,
    parameter  int OP_W    = 15,
    localparam int SEL_W   = $clog2(NUM_MR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [OP_W-1:0]        wr_data,
    output logic [NUM_MR*OP_W-1:0] regs
);
    typedef struct packed {
        logic [NUM_MR-1:0][OP_W-1:0] mr;
    } mr_t;

    mr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mr[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs = st_q.mr;
endmodule

// File: rtl/ddr3_bank_table.sv
module ddr3_bank_table #(
    parameter  int NUM_BANKS = 8,
    parameter  int ROW_W     = 15,
    localparam int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       act_en,
    input  logic [BA_W-1:0]            act_idx,
    input  logic [ROW_W-1:0]           act_row,
    input  logic                       close_en,
    input  logic [BA_W-1:0]            close_idx,
    input  logic                       close_all,
    output logic [NUM_BANKS-1:0]       open_vec,
    output logic [NUM_BANKS*ROW_W-1:0] rows
);
    typedef struct packed {
        logic [NUM_BANKS-1:0]            open;
        logic [NUM_BANKS-1:0][ROW_W-1:0] row;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (act_en && act_idx == BA_W'(b)) begin
                st_d.open[b] = 1'b1;
                st_d.row[b]  = act_row;
            end
            if (close_all || (close_en && close_idx == BA_W'(b))) begin
                st_d.open[b] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_vec = st_q.open;
    assign rows     = st_q.row;
endmodule

// File: rtl/ddr3_cmd_frontend.sv
module ddr3_cmd_frontend
    import ddr3_cmd_pkg::*;
#(
    parameter  int NUM_BANKS = 8,
    parameter  int ADDR_W    = 15,
    parameter  int COL_W     = 10,
    parameter  int AP_BIT    = 10,
    parameter  int CHOP_BIT  = 12,
    parameter  int NUM_MR    = 4,
    localparam int BA_W      = $clog2(NUM_BANKS),
    localparam int MRSEL_W   = $clog2(NUM_MR),
    localparam int ROW_W     = ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke,
    input  logic                     cs_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     we_n,
    input  logic [BA_W-1:0]          ba,
    input  logic [ADDR_W-1:0]        addr,
    output logic                     cmd_valid,
    output logic [2:0]               cmd_kind,
    output logic [BA_W-1:0]          cmd_bank,
    output logic [ROW_W-1:0]         cmd_row,
    output logic [COL_W-1:0]         cmd_col,
    output logic                     cmd_autopre,
    output logic                     cmd_burst8,
    output logic                     cmd_allbank,
    output logic                     proto_err,
    output logic [NUM_BANKS-1:0]     bank_open,
    output logic [NUM_MR*ADDR_W-1:0] mode_regs
);
    typedef struct packed {
        logic             valid;
        ev_e              kind;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             ap;
        logic             b8;
        logic             allb;
        logic             err;
    } ev_out_t;

    ev_out_t out_d, out_q;

    ev_e                        kind_w;
    logic                       burst8_w;
    logic [NUM_BANKS*ROW_W-1:0] rows_w;
    logic                       act_en, close_en, close_all, mr_we;

    ddr3_cmd_classify u_classify (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .kind  (kind_w)
    );

    ddr3_burst_resolve u_burst (
        .bl_mode  (mode_regs[1:0]),
        .chop_pin (addr[CHOP_BIT]),
        .burst8   (burst8_w)
    );

    ddr3_mode_regs #(.NUM_MR(NUM_MR), .OP_W(ADDR_W)) u_mregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mr_we),
        .wr_sel  (ba[MRSEL_W-1:0]),
        .wr_data (addr),
        .regs    (mode_regs)
    );

    ddr3_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_en    (act_en),
        .act_idx   (ba),
        .act_row   (addr),
        .close_en  (close_en),
        .close_idx (ba),
        .close_all (close_all),
        .open_vec  (bank_open),
        .rows      (rows_w)
    );

    always_comb begin
        out_d     = '0;
        act_en    = 1'b0;
        close_en  = 1'b0;
        close_all = 1'b0;
        mr_we     = 1'b0;
        if (cke && kind_w != EV_NOP) begin
            out_d.kind = kind_w;
            out_d.bank = ba;
            unique case (kind_w)
                EV_ACT: begin
                    if (bank_open[ba]) begin
                        out_d.err = 1'b1;
                    end else begin
                        out_d.valid = 1'b1;
                        out_d.row   = addr;
                        act_en      = 1'b1;
                    end
                end
                EV_RD, EV_WR: begin
                    if (!bank_open[ba]) begin
                        out_d.err = 1'b1;
                    end else begin
                        out_d.valid = 1'b1;
                        out_d.col   = addr[COL_W-1:0];
                        out_d.row   = rows_w[ba*ROW_W +: ROW_W];
                        out_d.ap    = addr[AP_BIT];
                        out_d.b8    = burst8_w;
                        close_en    = addr[AP_BIT];
                    end
                end
                EV_PRE: begin
                    out_d.valid = 1'b1;
                    out_d.allb  = addr[AP_BIT];
                    close_all   = addr[AP_BIT];
                    close_en    = !addr[AP_BIT];
                end
                EV_MRS: begin
                    out_d.valid = 1'b1;
                    mr_we       = 1'b1;
                end
                EV_REF: begin
                    if (|bank_open) out_d.err   = 1'b1;
                    else            out_d.valid = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cmd_valid   = out_q.valid;
    assign cmd_kind    = out_q.kind;
    assign cmd_bank    = out_q.bank;
    assign cmd_row     = out_q.row;
    assign cmd_col     = out_q.col;
    assign cmd_autopre = out_q.ap;
    assign cmd_burst8  = out_q.b8;
    assign cmd_allbank = out_q.allb;
    assign proto_err   = out_q.err;
endmodule

// File: rtl/ddr3_cmd_frontend_chk.sv
module ddr3_cmd_frontend_chk
    import ddr3_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 15,
    parameter int NUM_MR    = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cke,
    input logic                         cs_n,
    input logic                         cmd_valid,
    input logic [2:0]                   cmd_kind,
    input logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input logic                         cmd_allbank,
    input logic                         proto_err,
    input logic [NUM_BANKS-1:0]         bank_open,
    input logic [NUM_MR*ADDR_W-1:0]     mode_regs
);
    // R1
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && proto_err));

    // R3
    suspend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (!cmd_valid && !proto_err));

    // R3
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(bank_open) && $stable(mode_regs)));

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && cs_n) |=> (!cmd_valid && !proto_err && $stable(bank_open) && $stable(mode_regs)));

    // R5 R7 R11
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $stable(bank_open));

    // R4
    act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == EV_ACT) |-> bank_open[cmd_bank]);

    // R8
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == EV_PRE && cmd_allbank) |-> (bank_open == '0));

    // R11
    ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == EV_REF) |-> (bank_open == '0 && $stable(bank_open)));
endmodule

bind ddr3_cmd_frontend ddr3_cmd_frontend_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .NUM_MR    (NUM_MR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke         (cke),
    .cs_n        (cs_n),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .cmd_bank    (cmd_bank),
    .cmd_allbank (cmd_allbank),
    .proto_err   (proto_err),
    .bank_open   (bank_open),
    .mode_regs   (mode_regs)
);

// File: tb/ddr3_cmd_frontend_test.sv
`timescale 1ns/1ps
module ddr3_cmd_frontend_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [14:0] addr = '0;

    logic        cmd_valid, cmd_autopre, cmd_burst8, cmd_allbank, proto_err;
    logic [2:0]  cmd_kind, cmd_bank;
    logic [14:0] cmd_row;
    logic [9:0]  cmd_col;
    logic [7:0]  bank_open;
    logic [59:0] mode_regs;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    bit          m_open [8];
    logic [14:0] m_row  [8];
    logic [14:0] m_mr   [4];

    always #10 clk = ~clk;

    ddr3_cmd_frontend uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_autopre(cmd_autopre),
        .cmd_burst8(cmd_burst8), .cmd_allbank(cmd_allbank),
        .proto_err(proto_err), .bank_open(bank_open), .mode_regs(mode_regs)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        logic [7:0]  eo;
        logic [59:0] em;
        for (int b = 0; b < 8; b++) eo[b] = m_open[b];
        for (int i = 0; i < 4; i++) em[i*15 +: 15] = m_mr[i];
        chk(req, "bank_open", 64'(bank_open), 64'(eo));
        chk(req, "mode_regs", 64'(mode_regs), 64'(em));
    endtask

    // Drive one sample at a falling edge, check after the next rising edge.
    task automatic issue(input string req, input logic ck, input logic [3:0] code,
                         input logic [2:0] b, input logic [14:0] a);
        int k;
        logic ev, ee, eap, eb8, eall;
        logic [14:0] erow;
        logic [9:0]  ecol;
        logic [2:0]  ebank;
        bit any;
        k = 0; ev = 0; ee = 0; eap = 0; eb8 = 0; eall = 0;
        erow = '0; ecol = '0; ebank = '0;
        if (ck && !code[3]) begin
            case (code[2:0])
                3'b000: k = 5;
                3'b001: k = 6;
                3'b010: k = 4;
                3'b011: k = 1;
                3'b100: k = 3;
                3'b101: k = 2;
                default: k = 0;
            endcase
        end
        if (k != 0) ebank = b;
        case (k)
            1: if (m_open[b]) ee = 1;
               else begin ev = 1; erow = a; m_open[b] = 1; m_row[b] = a; end
            2, 3: if (!m_open[b]) ee = 1;
               else begin
                   ev = 1; ecol = a[9:0]; erow = m_row[b]; eap = a[10];
                   case (m_mr[0][1:0])
                       2'b01:   eb8 = a[12];
                       2'b10:   eb8 = 1'b0;
                       default: eb8 = 1'b1;
                   endcase
                   if (a[10]) m_open[b] = 0;
               end
            4: begin
                   ev = 1; eall = a[10];
                   if (a[10]) for (int i = 0; i < 8; i++) m_open[i] = 0;
                   else m_open[b] = 0;
               end
            5: begin ev = 1; m_mr[b[1:0]] = a; end
            6: begin
                   any = 0;
                   for (int i = 0; i < 8; i++) if (m_open[i]) any = 1;
                   if (any) ee = 1; else ev = 1;
               end
            default: ;
        endcase
        cke = ck; {cs_n, ras_n, cas_n, we_n} = code; ba = b; addr = a;
        @(posedge clk);
        @(negedge clk);
        chk(req, "valid", 64'(cmd_valid), 64'(ev));
        chk(req, "err", 64'(proto_err), 64'(ee));
        chk(req, "kind", 64'(cmd_kind), 64'(k));
        chk(req, "bank", 64'(cmd_bank), 64'(ebank));
        chk(req, "row", 64'(cmd_row), 64'(erow));
        chk(req, "col", 64'(cmd_col), 64'(ecol));
        chk(req, "autopre", 64'(cmd_autopre), 64'(eap));
        chk(req, "burst8", 64'(cmd_burst8), 64'(eb8));
        chk(req, "allbank", 64'(cmd_allbank), 64'(eall));
        check_state(req);
        cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_row[i] = '0; end
        for (int i = 0; i < 4; i++) m_mr[i] = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "valid", 64'(cmd_valid), 64'd0);
        chk("R12", "kind", 64'(cmd_kind), 64'd0);
        chk("R12", "err", 64'(proto_err), 64'd0);
        check_state("R12");
        rst_n = 1'b1;
        @(negedge clk);

        // R4: open every bank
        for (int b = 0; b < 8; b++) issue("R4", 1, 4'b0011, 3'(b), 15'(b * 4099 + 17));
        // R11: refresh with open banks
        issue("R11", 1, 4'b0001, 3'd0, 15'd0);
        // R5: activate an open bank
        issue("R5", 1, 4'b0011, 3'd3, 15'h1234);

        // R10 R6: every mode, bank, chop bit, read and write
        for (int m = 0; m < 4; m++) begin
            issue("R9", 1, 4'b0000, 3'd0, 15'(m));
            for (int b = 0; b < 8; b++)
                for (int c = 0; c < 2; c++) begin
                    issue("R10", 1, 4'b0101, 3'(b), 15'((c << 12) | ((b * 91 + m * 13 + 3) & 10'h3ff)));
                    issue("R6", 1, 4'b0100, 3'(b), 15'((c << 12) | ((b * 57 + m * 29 + 1) & 10'h3ff)));
                end
        end

        // R6: auto-precharge closes bank 2; R7: access then errors
        issue("R6", 1, 4'b0101, 3'd2, 15'h0400 | 15'd77);
        issue("R7", 1, 4'b0101, 3'd2, 15'd5);
        issue("R7", 1, 4'b0100, 3'd2, 15'd6);
        // R8: single-bank precharge, then all-bank
        issue("R8", 1, 4'b0010, 3'd5, 15'd0);
        issue("R7", 1, 4'b0100, 3'd5, 15'd1);
        issue("R8", 1, 4'b0010, 3'd6, 15'h0400);
        // R11: refresh when idle
        issue("R11", 1, 4'b0001, 3'd0, 15'd0);
        // R8: precharge of an idle bank is still valid
        issue("R8", 1, 4'b0010, 3'd1, 15'd0);

        // R3: clock enable low masks activate and mode load
        issue("R3", 0, 4'b0011, 3'd4, 15'h0abc);
        issue("R3", 0, 4'b0000, 3'd1, 15'h7fff);
        // R2: deselected samples
        issue("R2", 1, 4'b1011, 3'd4, 15'h0abc);
        issue("R2", 1, 4'b1000, 3'd2, 15'h5555);
        // R13: unused codes
        issue("R13", 1, 4'b0110, 3'd4, 15'h0abc);
        issue("R13", 1, 4'b0111, 3'd4, 15'h0abc);

        // R9: all four registers, with and without ba[2]
        for (int i = 0; i < 8; i++) issue("R9", 1, 4'b0000, 3'(i), 15'(i * 3001 + 9));

        // R1: open bank 4 then read after the state is known
        issue("R1", 1, 4'b0011, 3'd4, 15'h2468);
        issue("R1", 1, 4'b0101, 3'd4, 15'h1155);
        issue("R1", 1, 4'b0010, 3'd4, 15'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule